// File: doc/BRIEF.md
# Single-Digit Decimal Counter

This block is one synchronous decimal digit. Its 4-bit count steps 0, 1, ..., 9 and then back to 0 on rising clock edges while both of its count-enable inputs are high. It holds its value when either enable is low. An active-low synchronous load copies a 4-bit value into the count. An active-low asynchronous clear forces the count to zero at once, with no clock edge needed.

A carry output reports the terminal count while counting is enabled. The carry is combinational. It can drive the enables of a following digit in the same cycle, so that several instances form a multi-digit decimal counter that shares one clock.

If a value outside the decimal range is loaded, the counter does not lock up. The next enabled edge takes it back to zero.

Top module: `decade_digit_counter`

## Requirements
- R1: While `clr_n` is low, `count` is 0000. The clear acts without a clock edge and overrides every other input.
- R2: With `clr_n` high and `load_n` low, a rising edge sets `count` to `din`, with `din[3]` as the most significant bit. This happens even when both enables are low.
- R3: With `clr_n` and `load_n` high, both enables high and `count` below 9, a rising edge adds one to `count`.
- R4: With `clr_n` and `load_n` high and either enable low, `count` does not change across an edge.
- R5: With `clr_n` and `load_n` high, both enables high and `count` equal to 9 (1001), a rising edge sets `count` to 0000.
- R6: With `clr_n` and `load_n` high, both enables high and `count` at any code from 1010 to 1111, a rising edge sets `count` to 0000.
- R7: `carry` is 1 exactly when `en_a` and `en_b` are both 1 and `count` is 1001. It follows those inputs in the same cycle, without a clock edge.
- R8: If `clr_n` goes low while `load_n` is low, `count` is 0000 and stays 0000 across the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock, rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| en_a | input | 1 | Count enable, active high |
| en_b | input | 1 | Count enable, active high |
| din | input | 4 | Value to load, bit 3 most significant |
| count | output | 4 | Current digit value |
| carry | output | 1 | Terminal-count flag, gated by both enables |

## Verification
In normal counting the register never leaves 0 to 9. The six codes above 9 can only be reached with a parallel load. The bench therefore loads every 4-bit value. After each load it applies every enable combination and checks the step, the hold, the wrap or the recovery to zero.

The clear racing a pending load is the other hard case. To reach it, the bench drops the clear between clock edges while the load is low. It checks the count before the next edge and again after that edge.

// File: rtl/dcd_pkg.sv
package dcd_pkg;
  localparam int DIGIT_W = 4;
  localparam int RADIX   = 10;
  localparam logic [DIGIT_W-1:0] TOP_VAL = DIGIT_W'(RADIX - 1);
  typedef logic [DIGIT_W-1:0] digit_t;
endpackage

// File: rtl/dcd_next.sv
module dcd_next
  import dcd_pkg::*;
(
  input  digit_t cur,
  input  logic   load_n,
  input  logic   step,
  input  digit_t din,
  output digit_t nxt
);
  digit_t inc;
  // Any code at or above the terminal value (including illegal codes) returns to zero.
  assign inc = (cur >= TOP_VAL) ? '0 : cur + digit_t'(1);

  always_comb begin
    if (!load_n)   nxt = din;
    else if (step) nxt = inc;
    else           nxt = cur;
  end
endmodule

// File: rtl/dcd_carry.sv
module dcd_carry
  import dcd_pkg::*;
(
  input  digit_t cur,
  input  logic   step,
  output logic   carry
);
  assign carry = step & (cur == TOP_VAL);
endmodule

// File: rtl/decade_digit_counter.sv
module decade_digit_counter
  import dcd_pkg::*;
(
  input  logic         clk,
  input  logic         clr_n,
  input  logic         load_n,
  input  logic         en_a,
  input  logic         en_b,
  input  logic [3:0]   din,
  output logic [3:0]   count,
  output logic         carry
);
  digit_t q, q_nxt;
  logic   step;

  assign step = en_a & en_b;

  dcd_next u_next (
    .cur(q), .load_n(load_n), .step(step), .din(din), .nxt(q_nxt)
  );

  dcd_carry u_carry (
    .cur(q), .step(step), .carry(carry)
  );

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) q <= '0;
    else        q <= q_nxt;
  end

  assign count = q;
endmodule

// File: rtl/dcd_checker.sv
module dcd_checker (
  input logic       clk,
  input logic       clr_n,
  input logic       load_n,
  input logic       en_a,
  input logic       en_b,
  input logic [3:0] din,
  input logic [3:0] count,
  input logic       carry
);
  always @(posedge clk) begin
    if (!clr_n) a_r1_clear_zero: assert (count == 4'd0);
    a_r7_carry: assert (carry == (en_a && en_b && count == 4'd9));
  end

  a_r2_load: assert property (@(posedge clk) disable iff (!clr_n)
    !load_n |=> count == $past(din));

  a_r3_increment: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_a && en_b && count < 4'd9) |=> count == $past(count) + 4'd1);

  a_r4_hold: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && !(en_a && en_b)) |=> $stable(count));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_a && en_b && count == 4'd9) |=> count == 4'd0);

  a_r6_illegal_recover: assert property (@(posedge clk) disable iff (!clr_n)
    (load_n && en_a && en_b && count > 4'd9) |=> count == 4'd0);
endmodule

bind decade_digit_counter dcd_checker u_chk (
  .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_a(en_a), .en_b(en_b),
  .din(din), .count(count), .carry(carry)
);

// File: tb/sim_decade_digit_counter.sv
module sim_decade_digit_counter;
  logic       clk = 1'b0;
  logic       clr_n = 1'b0;
  logic       load_n = 1'b1;
  logic       en_a = 1'b0;
  logic       en_b = 1'b0;
  logic [3:0] din = 4'd0;
  logic [3:0] count;
  logic       carry;
  int checks = 0;
  int fails = 0;
  int model = 0;

  always #10 clk = ~clk;

  decade_digit_counter u0 (
    .clk(clk), .clr_n(clr_n), .load_n(load_n), .en_a(en_a), .en_b(en_b),
    .din(din), .count(count), .carry(carry)
  );

  task automatic chk(input string tag, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, expv, $time);
    end
  endtask

  // Called at a negedge: drive, check carry, clock, then check count.
  task automatic apply(input logic ld_n, input logic ea, input logic eb, input int d);
    string tag;
    load_n = ld_n; en_a = ea; en_b = eb; din = 4'(d);
    #1;
    chk("R7 carry", int'(carry), (ea && eb && model == 9) ? 1 : 0);
    if (!ld_n)             begin tag = "R2 load";      model = d; end
    else if (!(ea && eb))  tag = "R4 hold";
    else if (model > 9)    begin tag = "R6 illegal";   model = 0; end
    else if (model == 9)   begin tag = "R5 wrap";      model = 0; end
    else                   begin tag = "R3 increment"; model = model + 1; end
    @(posedge clk);
    @(negedge clk);
    chk(tag, int'(count), model);
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset state", int'(count), 0);
    clr_n = 1'b1;
    model = 0;
    // Long enabled run: counting, wrap and carry over several decades.
    for (int i = 0; i < 25; i++) apply(1'b1, 1'b1, 1'b1, 0);
    // Exhaustive: every loaded code times every enable combination.
    for (int v = 0; v < 16; v++) begin
      for (int e = 0; e < 4; e++) begin
        apply(1'b0, e[0], e[1], v);   // load regardless of enables (R2)
        apply(1'b1, e[0], e[1], 0);   // hold or step
        apply(1'b1, 1'b1, 1'b1, 0);   // enabled step
      end
    end
    // Asynchronous clear between edges: no clock needed (R1).
    apply(1'b0, 1'b0, 1'b0, 6);
    #3 clr_n = 1'b0;
    #2 chk("R1 async clear", int'(count), 0);
    model = 0;
    // Clear beats a pending load (R8).
    @(negedge clk);
    load_n = 1'b0; din = 4'd7; en_a = 1'b1; en_b = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk("R8 clear over load", int'(count), 0);
    chk("R7 carry during clear", int'(carry), 0);
    clr_n = 1'b1;
    apply(1'b0, 1'b1, 1'b1, 9);
    apply(1'b1, 1'b1, 1'b1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule